// File: doc/BRIEF.md
# Address-Selected Endian Bus Adapter

This adapter joins a 32-bit bus master to a group of memory-mapped peripherals. The byte order of each access is set by one address bit and not by any mode register. With that bit clear, data and byte enables pass straight through in little-endian order. With it set, the four byte lanes of the write data, the byte enables and the read data are all mirrored, so the master sees the peripheral as big-endian. Every device therefore shows up twice in the address map, once as a little-endian alias and once as a big-endian alias, and both aliases reach the same registers.

Each device takes a window of two 16 kB pages: the lower page is the little-endian alias and the upper page is the big-endian alias. Every window therefore starts on a page boundary and can be mapped on its own. The byte reversal is plain lane multiplexing and adds no register stage on the data path. The byte order and the target device are latched when an access starts and are held until it is acknowledged. An access that falls outside every window is acknowledged by the adapter itself and returns zero, so the bus cannot hang.

Top module: `endian_bus_bridge`

## Requirements
- R1: An access with address bit 14 clear reaches the peripheral with write data and byte enables unchanged, in the same cycle the master presents them.
- R2: An access with address bit 14 set reaches the peripheral with write data byte lane i (bits 8i+7:8i) moved to lane 3-i.
- R3: On a big-endian access the byte enables are mirrored the same way (enable bit i drives bit 3-i), so byte and halfword writes land on the mirrored lanes.
- R4: Read data returns unchanged through the little-endian alias and with byte lane i moved to lane 3-i through the big-endian alias.
- R5: Address bits 23:15 equal to BASE_WIN+k assert only strobe bit k, and at most one strobe bit is ever high.
- R6: The peripheral sees address bits 13:0 only, so both aliases of one device reach the same stored word.
- R7: An access that matches no window raises no device strobe and is acknowledged one cycle after the strobe, with zero read data.
- R8: The byte order used for read data is the one the address had when the access started, held until acknowledge even if the address changes meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_stb | input | 1 | Master request, held until acknowledge |
| m_we | input | 1 | Master write when high |
| m_addr | input | 24 | Master byte address |
| m_be | input | 4 | Master byte enables |
| m_wdata | input | 32 | Master write data |
| m_rdata | output | 32 | Read data returned to the master |
| m_ack | output | 1 | Acknowledge to the master |
| s_stb | output | 4 | One strobe per device |
| s_we | output | 1 | Write enable to the devices |
| s_addr | output | 14 | Offset within the device page |
| s_be | output | 4 | Byte enables to the devices, after mirroring |
| s_wdata | output | 32 | Write data to the devices, after mirroring |
| s_rdata | input | 128 | Read data from the devices, device k in bits 32k+31:32k |
| s_ack | input | 4 | Acknowledge from each device |

## Verification
The hardest case to reach is a big-endian read whose address changes while the access waits for its acknowledge. A correct master never does that, but it is the only way to see whether the byte order was latched or is still being taken from the live address. The bench starts a read through the big-endian alias, clears bit 14 one cycle later while keeping the strobe high, and expects the read data to come back still reversed. Mixed-width writes through one alias, followed by reads through the other alias, check that the lane mirroring and the shared offset agree with each other.

// File: rtl/endian_bus_bridge.sv
module endian_bus_bridge #(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 32,
  parameter int PAGE_W   = 14,
  parameter int NUM_DEV  = 4,
  parameter int BASE_WIN = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      m_stb,
  input  logic                      m_we,
  input  logic [ADDR_W-1:0]         m_addr,
  input  logic [DATA_W/8-1:0]       m_be,
  input  logic [DATA_W-1:0]         m_wdata,
  output logic [DATA_W-1:0]         m_rdata,
  output logic                      m_ack,
  output logic [NUM_DEV-1:0]        s_stb,
  output logic                      s_we,
  output logic [PAGE_W-1:0]         s_addr,
  output logic [DATA_W/8-1:0]       s_be,
  output logic [DATA_W-1:0]         s_wdata,
  input  logic [NUM_DEV*DATA_W-1:0] s_rdata,
  input  logic [NUM_DEV-1:0]        s_ack
);
  localparam int NB       = DATA_W / 8;
  localparam int SWAP_BIT = PAGE_W;
  localparam int WIN_W    = ADDR_W - PAGE_W - 1;
  localparam int DEV_W    = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  logic [WIN_W-1:0] win;
  logic             hit, hit_q, hit_now;
  logic [DEV_W-1:0] dev, dev_q, dev_now;
  logic             active, swap_q, swap_now, miss_ack;
  logic [DATA_W-1:0] wd_rev, rd_sel, rd_rev;
  logic [NB-1:0]     be_rev;

  assign win = m_addr[ADDR_W-1:PAGE_W+1];

  always_comb begin
    hit = 1'b0;
    dev = '0;
    for (int k = 0; k < NUM_DEV; k++)
      if (win == WIN_W'(BASE_WIN + k)) begin
        hit = 1'b1;
        dev = DEV_W'(k);
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      swap_q   <= 1'b0;
      dev_q    <= '0;
      hit_q    <= 1'b0;
      miss_ack <= 1'b0;
    end else begin
      active   <= m_stb & ~m_ack;
      miss_ack <= m_stb & ~hit_now & ~miss_ack;
      if (m_stb && !active) begin
        swap_q <= m_addr[SWAP_BIT];
        dev_q  <= dev;
        hit_q  <= hit;
      end
    end
  end

  assign swap_now = active ? swap_q : m_addr[SWAP_BIT];
  assign dev_now  = active ? dev_q  : dev;
  assign hit_now  = active ? hit_q  : hit;

  assign rd_sel = s_rdata[dev_now*DATA_W +: DATA_W];

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign wd_rev[8*i +: 8] = m_wdata[8*(NB-1-i) +: 8];
    assign rd_rev[8*i +: 8] = rd_sel[8*(NB-1-i) +: 8];
    assign be_rev[i]        = m_be[NB-1-i];
  end

  assign s_stb   = (m_stb && hit_now) ? (NUM_DEV'(1) << dev_now) : '0;
  assign s_we    = m_we;
  assign s_addr  = m_addr[PAGE_W-1:0];
  assign s_be    = swap_now ? be_rev : m_be;
  assign s_wdata = swap_now ? wd_rev : m_wdata;
  assign m_ack   = miss_ack | (m_stb & hit_now & s_ack[dev_now]);
  assign m_rdata = !hit_now ? '0 : (swap_now ? rd_rev : rd_sel);

  assert_one_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_stb));
  assert_be_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|s_stb) |-> $countones(s_be) == $countones(m_be));
  assert_miss_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_stb && !hit && !active) |=> (m_ack || !m_stb));
  assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_ack && !hit_now) |-> m_rdata == '0);
  assert_swap_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && m_stb) |-> swap_now == $past(swap_now));
endmodule

// File: tb/endian_bus_bridge_tb.sv
module endian_bus_bridge_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic m_stb = 1'b0, m_we = 1'b0;
  logic [23:0] m_addr = '0;
  logic [3:0]  m_be = '0;
  logic [31:0] m_wdata = '0;
  logic [31:0] m_rdata;
  logic        m_ack;
  logic [3:0]  s_stb, s_be, s_ack;
  logic        s_we;
  logic [13:0] s_addr;
  logic [31:0] s_wdata;
  logic [127:0] s_rdata;
  logic [31:0] mem [4][16];
  logic [31:0] rq [4];
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  endian_bus_bridge u_dut (.clk(clk), .rst_n(rst_n), .m_stb(m_stb), .m_we(m_we),
    .m_addr(m_addr), .m_be(m_be), .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ack(m_ack),
    .s_stb(s_stb), .s_we(s_we), .s_addr(s_addr), .s_be(s_be), .s_wdata(s_wdata),
    .s_rdata(s_rdata), .s_ack(s_ack));

  always @(posedge clk) begin
    for (int d = 0; d < 4; d++) begin
      if (!rst_n) begin
        s_ack[d] <= 1'b0;
        rq[d] <= '0;
        for (int w = 0; w < 16; w++) mem[d][w] <= '0;
      end else begin
        s_ack[d] <= s_stb[d] & ~s_ack[d];
        if (s_stb[d] && !s_ack[d]) begin
          rq[d] <= mem[d][s_addr[5:2]];
          if (s_we)
            for (int b = 0; b < 4; b++)
              if (s_be[b]) mem[d][s_addr[5:2]][8*b +: 8] <= s_wdata[8*b +: 8];
        end
      end
    end
  end
  assign s_rdata = {rq[3], rq[2], rq[1], rq[0]};

  function automatic logic [23:0] le(input int k, input int off);
    return 24'((16 + k) << 15) | 24'(off);
  endfunction
  function automatic logic [23:0] bea(input int k, input int off);
    return le(k, off) | 24'h004000;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] o_rd, o_wd;
  logic [3:0]  o_be, o_stb;
  logic [13:0] o_addr;

  task automatic acc(input logic [23:0] a, input logic we, input logic [3:0] be,
                     input logic [31:0] wd, input logic flip);
    int n = 0;
    @(negedge clk);
    m_addr = a; m_we = we; m_be = be; m_wdata = wd; m_stb = 1'b1;
    #1;
    o_wd = s_wdata; o_be = s_be; o_stb = s_stb; o_addr = s_addr;
    if (flip) begin
      @(posedge clk);
      #1 m_addr[14] = 1'b0;
    end
    do begin
      @(negedge clk);
      n++;
    end while (!m_ack && n < 20);
    if (!m_ack) chk("ack", 32'(m_ack), 32'd1);
    o_rd = m_rdata;
    m_stb = 1'b0; m_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R7 reset ack", 32'(m_ack), 0);
    chk("R5 reset stb", 32'(s_stb), 0);
  endtask

  task automatic t_le_word;
    acc(le(1, 8), 1, 4'hF, 32'h11223344, 0);
    chk("R1 wdata", o_wd, 32'h11223344);
    chk("R1 be", 32'(o_be), 32'hF);
    chk("R5 stb dev1", 32'(o_stb), 32'h2);
    acc(le(1, 8), 0, 4'hF, 0, 0);
    chk("R4 le read", o_rd, 32'h11223344);
    acc(bea(1, 8), 0, 4'hF, 0, 0);
    chk("R4 be read", o_rd, 32'h44332211);
    chk("R6 offset", 32'(o_addr), 32'h8);
  endtask

  task automatic t_be_narrow;
    acc(bea(2, 4), 1, 4'b0001, 32'h000000AA, 0);
    chk("R2 byte wdata", o_wd, 32'hAA000000);
    chk("R3 byte be", 32'(o_be), 32'b1000);
    chk("R5 stb dev2", 32'(o_stb), 32'h4);
    acc(bea(2, 4), 1, 4'b1100, 32'hBEEF0000, 0);
    chk("R2 half wdata", o_wd, 32'h0000EFBE);
    chk("R3 half be", 32'(o_be), 32'b0011);
    acc(le(2, 4), 0, 4'hF, 0, 0);
    chk("R6 alias le view", o_rd, 32'hAA00EFBE);
    acc(bea(2, 4), 0, 4'hF, 0, 0);
    chk("R4 alias be view", o_rd, 32'hBEEF00AA);
  endtask

  task automatic t_miss;
    acc(24'h000010, 0, 4'hF, 0, 0);
    chk("R7 miss stb", 32'(o_stb), 0);
    chk("R7 miss data", o_rd, 0);
    acc(le(4, 0), 1, 4'hF, 32'hDEADBEEF, 0);
    chk("R7 past last window", 32'(o_stb), 0);
    acc(le(0, 0), 0, 4'hF, 0, 0);
    chk("R7 no stray write", o_rd, 0);
  endtask

  task automatic t_hold;
    acc(le(3, 0), 1, 4'hF, 32'h01020304, 0);
    acc(bea(3, 0), 0, 4'hF, 0, 1);
    chk("R8 held swap", o_rd, 32'h04030201);
  endtask

  initial begin
    #(8 * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_le_word();
    t_be_narrow();
    t_miss();
    t_hold();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule